// File: doc/BRIEF.md
# Terminating Recursive Systematic Convolutional Encoder

This block codes one frame at a time with a recursive systematic convolutional code built around a three-stage shift register, which gives eight trellis states. A frame opens with a single-cycle start pulse. The same pulse carries the frame length k. The k data bits then arrive serially over a valid/ready handshake. For every accepted bit, the block emits a systematic bit and a redundancy bit one cycle later.

Once the k-th bit has been accepted, the encoder stops taking data and runs ν = 3 tail cycles. In each tail cycle the encoder input is the register's own feedback value. This drives a zero into the first stage on every tail cycle, so the register ends in state zero. Redundancy is still produced during the tail, so every frame is k + ν symbols long. The last tail symbol carries a frame-done flag. The register contents are brought out so that a decoder-side model or a bench can confirm the final state.

The register is cleared when a frame is accepted, and the clear adds no symbol to the output. The feedback polynomial is 1 + D^2 + D^3 and the redundancy polynomial is 1 + D + D^3.

Top module: `rsc_tail_encoder`

## Requirements
- R1: An accepted start pulse clears the shift register to all zeros. `trellis_state` reads 0 on the cycle after the pulse.
- R2: An accepted start emits no output symbol. Each frame puts out exactly k + 3 symbols on `out_valid`, and no others.
- R3: For a data bit d accepted in cycle t, with state bits s1 (newest), s2 and s3:
  - the first-stage input is a = d ^ s2 ^ s3;
  - `out_sys` = d and `out_red` = a ^ s1 ^ s3;
  - both appear with `out_valid` = 1 in cycle t+1;
  - the new state is (s1, s2, s3) = (a, s1, s2).
- R4: After the k-th data bit, exactly 3 tail symbols follow with `out_tail` = 1. Data symbols carry `out_tail` = 0.
- R5: On a tail cycle:
  - the encoder input equals the feedback value s2 ^ s3;
  - `out_sys` carries that value;
  - the first-stage input is 0;
  - `out_red` follows the R3 formula.
- R6: `frame_done` is 1 only together with the third tail symbol. At that point `trellis_state` = 0.
- R7: `in_ready` is 1 only while data bits of a frame are still outstanding. It is 0 in idle and during the tail, and a valid bit offered then is not consumed.
- R8: A start pulse that arrives while a frame is in progress (data or tail phase) is ignored. It does not restart the frame and does not open a new frame after `frame_done`.
- R9: A frame with k = 0 produces only the 3 tail symbols, all with `out_sys` = `out_red` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Single-cycle frame start; honoured only when idle |
| frame_len | input | LEN_W (8) | Number k of data bits, sampled with the start |
| in_valid | input | 1 | Data bit offered |
| in_bit | input | 1 | Data bit |
| in_ready | output | 1 | Encoder accepts a data bit this cycle |
| out_valid | output | 1 | Symbol present on the outputs |
| out_sys | output | 1 | Systematic bit (data or substituted feedback) |
| out_red | output | 1 | Redundancy bit |
| out_tail | output | 1 | Symbol belongs to the termination tail |
| frame_done | output | 1 | Last symbol of the frame |
| trellis_state | output | MEM_LEN (3) | Register contents; bit i holds the value delayed by i+1 cycles |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- **Last data bit to first tail cycle.** A design that gets the switch-over wrong either consumes an extra data bit or drops a tail symbol. Both show up as a length mismatch against the reference stream.
- **k = 0.** Data and tail then meet at the start cycle. A faulty design enters the data phase and waits forever for data.
- **Start pulses during the data phase and during the tail.** A design that honours them restarts the register, which corrupts the redundancy, or opens a stray frame after `frame_done`.
- **Feedback substitution.** A wrong tap or polynomial in the substituted bit leaves a nonzero final state. That is caught at `frame_done` over many random frames with irregular valid gaps.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int MAX_MEM = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2
  } phase_t;

  // Parity of the register bits picked by a tap mask (bit i = delay i+1).
  function automatic logic tap_parity(input logic [MAX_MEM-1:0] st,
                                      input logic [MAX_MEM-1:0] taps);
    return ^(st & taps);
  endfunction

  // Value entering the first stage for encoder input u.
  function automatic logic stage_in(input logic u,
                                    input logic [MAX_MEM-1:0] st,
                                    input logic [MAX_MEM-1:0] fb_taps);
    return u ^ tap_parity(st, fb_taps);
  endfunction

  // Redundancy: first-stage input plus the selected register taps.
  function automatic logic red_out(input logic a,
                                   input logic [MAX_MEM-1:0] st,
                                   input logic [MAX_MEM-1:0] red_taps);
    return a ^ tap_parity(st, red_taps);
  endfunction

endpackage

// File: rtl/rsc_phase_ctrl.sv
module rsc_phase_ctrl
  import rsc_pkg::*;
#(
  parameter int MEM_LEN = 3,
  parameter int LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             clear_en,
  output logic             step_en,
  output logic             tail_sel,
  output logic             last_tail
);

  localparam int CNT_W = $clog2(MEM_LEN + 1);
  localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(MEM_LEN - 1);

  phase_t           phase_q;
  logic [LEN_W-1:0] left_q;
  logic [CNT_W-1:0] tail_cnt_q;
  logic             take_data;

  always_comb begin
    in_ready  = (phase_q == PH_DATA);
    tail_sel  = (phase_q == PH_TAIL);
    clear_en  = frame_start && (phase_q == PH_IDLE);
    take_data = in_ready && in_valid;
    step_en   = take_data || tail_sel;
    last_tail = tail_sel && (tail_cnt_q == TAIL_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      left_q     <= '0;
      tail_cnt_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (clear_en) begin
            left_q     <= frame_len;
            tail_cnt_q <= '0;
            phase_q    <= (frame_len == '0) ? PH_TAIL : PH_DATA;
          end
        end
        PH_DATA: begin
          if (take_data) begin
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) begin
              phase_q    <= PH_TAIL;
              tail_cnt_q <= '0;
            end
          end
        end
        PH_TAIL: begin
          tail_cnt_q <= tail_cnt_q + 1'b1;
          if (last_tail) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rsc_trellis.sv
module rsc_trellis
  import rsc_pkg::*;
#(
  parameter int               MEM_LEN  = 3,
  parameter logic [MEM_LEN-1:0] FB_TAPS  = 3'b110,
  parameter logic [MEM_LEN-1:0] RED_TAPS = 3'b101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_en,
  input  logic               step_en,
  input  logic               tail_sel,
  input  logic               data_bit,
  output logic               sys_bit,
  output logic               red_bit,
  output logic               feedback,
  output logic               first_stage_in,
  output logic [MEM_LEN-1:0] state
);

  localparam logic [MAX_MEM-1:0] FB_W  = MAX_MEM'(FB_TAPS);
  localparam logic [MAX_MEM-1:0] RED_W = MAX_MEM'(RED_TAPS);

  logic [MEM_LEN-1:0] st_q;
  logic [MEM_LEN-1:0] st_next;
  logic [MAX_MEM-1:0] st_wide;

  assign st_wide  = MAX_MEM'(st_q);
  assign feedback = tap_parity(st_wide, FB_W);
  // Selector: external data while coding, own feedback while terminating.
  assign sys_bit        = tail_sel ? feedback : data_bit;
  assign first_stage_in = stage_in(sys_bit, st_wide, FB_W);
  assign red_bit        = red_out(first_stage_in, st_wide, RED_W);

  generate
    if (MEM_LEN == 1) begin : g_single
      assign st_next = first_stage_in;
    end else begin : g_shift
      assign st_next = {st_q[MEM_LEN-2:0], first_stage_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (clear_en) begin
      st_q <= '0;
    end else if (step_en) begin
      st_q <= st_next;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/rsc_out_stage.sv
module rsc_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic sys_bit,
  input  logic red_bit,
  input  logic tail_sel,
  input  logic last_tail,
  output logic out_valid,
  output logic out_sys,
  output logic out_red,
  output logic out_tail,
  output logic frame_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sys    <= 1'b0;
      out_red    <= 1'b0;
      out_tail   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      out_valid  <= step_en;
      out_sys    <= step_en & sys_bit;
      out_red    <= step_en & red_bit;
      out_tail   <= step_en & tail_sel;
      frame_done <= step_en & last_tail;
    end
  end

endmodule

// File: rtl/rsc_tail_encoder.sv
module rsc_tail_encoder #(
  parameter int                 MEM_LEN  = 3,
  parameter int                 LEN_W    = 8,
  parameter logic [MEM_LEN-1:0] FB_TAPS  = 3'b110,
  parameter logic [MEM_LEN-1:0] RED_TAPS = 3'b101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic               in_valid,
  input  logic               in_bit,
  output logic               in_ready,
  output logic               out_valid,
  output logic               out_sys,
  output logic               out_red,
  output logic               out_tail,
  output logic               frame_done,
  output logic [MEM_LEN-1:0] trellis_state
);

  // Named internal events, visible to the bound checker.
  logic clear_en;
  logic step_en;
  logic tail_sel;
  logic last_tail;
  logic sys_bit;
  logic red_bit;
  logic feedback;
  logic first_stage_in;

  rsc_phase_ctrl #(
    .MEM_LEN (MEM_LEN),
    .LEN_W   (LEN_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_len   (frame_len),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .clear_en    (clear_en),
    .step_en     (step_en),
    .tail_sel    (tail_sel),
    .last_tail   (last_tail)
  );

  rsc_trellis #(
    .MEM_LEN  (MEM_LEN),
    .FB_TAPS  (FB_TAPS),
    .RED_TAPS (RED_TAPS)
  ) u_trellis (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear_en       (clear_en),
    .step_en        (step_en),
    .tail_sel       (tail_sel),
    .data_bit       (in_bit),
    .sys_bit        (sys_bit),
    .red_bit        (red_bit),
    .feedback       (feedback),
    .first_stage_in (first_stage_in),
    .state          (trellis_state)
  );

  rsc_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .sys_bit    (sys_bit),
    .red_bit    (red_bit),
    .tail_sel   (tail_sel),
    .last_tail  (last_tail),
    .out_valid  (out_valid),
    .out_sys    (out_sys),
    .out_red    (out_red),
    .out_tail   (out_tail),
    .frame_done (frame_done)
  );

endmodule

// File: rtl/rsc_tail_encoder_chk.sv
module rsc_tail_encoder_chk #(
  parameter int MEM_LEN = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               in_ready,
  input logic               clear_en,
  input logic               step_en,
  input logic               tail_sel,
  input logic               first_stage_in,
  input logic               out_valid,
  input logic               out_tail,
  input logic               frame_done,
  input logic [MEM_LEN-1:0] trellis_state
);

  logic [7:0] tail_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   tail_run <= '0;
    else if (frame_done)          tail_run <= '0;
    else if (out_valid && out_tail) tail_run <= tail_run + 1'b1;
    else if (out_valid)           tail_run <= '0;
  end

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |=> (trellis_state == '0));

  p_clear_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |=> !out_valid);

  p_tail_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (tail_run == 8'(MEM_LEN - 1)));

  p_tail_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tail && !frame_done) |-> (tail_run < 8'(MEM_LEN - 1)));

  p_tail_input_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && tail_sel) |-> !first_stage_in);

  p_done_state_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (trellis_state == '0));

  p_done_on_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (out_valid && out_tail));

  p_ready_low_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tail_sel |-> !in_ready);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (tail_sel || in_ready)) |-> !clear_en);

endmodule

bind rsc_tail_encoder rsc_tail_encoder_chk #(.MEM_LEN(MEM_LEN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_start    (frame_start),
  .in_ready       (in_ready),
  .clear_en       (clear_en),
  .step_en        (step_en),
  .tail_sel       (tail_sel),
  .first_stage_in (first_stage_in),
  .out_valid      (out_valid),
  .out_tail       (out_tail),
  .frame_done     (frame_done),
  .trellis_state  (trellis_state)
);

// File: tb/test_rsc_tail_encoder.sv
module test_rsc_tail_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 3;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [LW-1:0] frame_len = '0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready, out_valid, out_sys, out_red, out_tail, frame_done;
  logic [NU-1:0] trellis_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsc_tail_encoder i_rsc_tail_encoder (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_len(frame_len),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .out_valid(out_valid), .out_sys(out_sys), .out_red(out_red),
    .out_tail(out_tail), .frame_done(frame_done), .trellis_state(trellis_state)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [3:0] exp_q[$];  // {sys, red, tail, done}
  int sr[1:3];           // sr[1] newest
  bit done_seen;
  bit zero_frame;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference: one encoder step with input u.
  function automatic void model_step(input int u, input bit tail, input bit last);
    int fbv, a, red;
    fbv = sr[2] ^ sr[3];
    a   = u ^ fbv;
    red = a ^ sr[1] ^ sr[3];
    exp_q.push_back({u[0], red[0], tail, last});
    sr[3] = sr[2];
    sr[2] = sr[1];
    sr[1] = a;
  endfunction

  function automatic void model_tail();
    for (int i = 0; i < NU; i++) model_step(sr[2] ^ sr[3], 1'b1, i == NU - 1);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "symbol beyond k+3", 1, 0);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(out_sys == e[3], zero_frame ? "R9" : (e[1] ? "R5" : "R3"), "out_sys", out_sys, e[3]);
          check(out_red == e[2], zero_frame ? "R9" : (e[1] ? "R5" : "R3"), "out_red", out_red, e[2]);
          check(out_tail == e[1], "R4", "out_tail", out_tail, e[1]);
          check(frame_done == e[0], "R6", "frame_done", frame_done, e[0]);
          if (frame_done) begin
            check(trellis_state == '0, "R6", "state at done", trellis_state, 0);
            done_seen = 1'b1;
          end
        end
      end else if (frame_done) begin
        check(1'b0, "R6", "done without symbol", 1, 0);
      end
    end
  end

  task automatic run_frame(input int k, input int gap, input bit poke_data, input bit poke_tail);
    int accepted;
    @(negedge clk);
    frame_start = 1'b1;
    frame_len   = LW'(k);
    sr[1] = 0; sr[2] = 0; sr[3] = 0;   // R1: cleared at start
    done_seen  = 1'b0;
    zero_frame = (k == 0);
    if (k == 0) model_tail();
    @(negedge clk);
    frame_start = 1'b0;
    accepted = 0;
    while (accepted < k) begin
      in_valid    = (($urandom % 100) >= gap);
      in_bit      = 1'($urandom);
      frame_start = poke_data && (accepted == 1);  // R8 in data phase
      if (in_valid && in_ready) begin
        model_step(in_bit, 1'b0, 1'b0);
        accepted++;
        if (accepted == k) model_tail();
      end
      @(negedge clk);
    end
    frame_start = poke_tail;  // R8 during tail
    in_valid    = 1'b1;
    in_bit      = 1'b1;
    check(in_ready == 1'b0, "R7", "ready in tail", in_ready, 0);
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < NU + 2; i++) begin
      check(in_ready == 1'b0, "R7", "ready after data", in_ready, 0);
      @(negedge clk);
    end
    check(done_seen, "R6", "frame_done seen", done_seen, 1);
    check(exp_q.size() == 0, "R2", "missing symbols", exp_q.size(), 0);
    in_valid = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(!out_valid && !in_ready, "R8", "no stray frame", out_valid, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R2", "reset out_valid", out_valid, 0);
    check(in_ready == 1'b0, "R7", "reset in_ready", in_ready, 0);
    check(trellis_state == '0, "R1", "reset state", trellis_state, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(0, 0, 1'b0, 1'b1);   // R9
    run_frame(1, 0, 1'b0, 1'b0);
    run_frame(5, 0, 1'b0, 1'b0);
    run_frame(16, 30, 1'b1, 1'b1);
    for (int i = 0; i < 14; i++)
      run_frame(1 + int'($urandom % 40), int'($urandom % 50), i % 2 == 0, i % 3 == 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule